// File: doc/BRIEF.md
# SCSI Controller Register Interface

This block is the host-side register file of a SCSI initiator controller. A processor reaches it through a synchronous byte bus. Each register index takes a 4-byte slot, so the index is bits 5:2 of a 6-bit address and bits 1:0 are ignored. At several indices a read and a write reach different storage. The transfer counter, for example, has a write side and a separate readable copy. The interrupt register has a read side effect.

A 32-byte FIFO carries command and status bytes under programmed I/O. Writing the command register decodes an opcode from bits 6:0. Bit 7 qualifies the command as DMA.

The block does not run the bus phases itself. It sends one-cycle start strobes to the selection sequencer and to the DMA engine. The sequencer reports back through an update port that loads the status, interrupt and sequence-step registers and raises the interrupt line. The block also handles chip reset, bus-reset reporting and the two response commands that return the status byte to the host.

Top module: `scsi_regif`

## Requirements
- R1: The register index is addr[5:2] and addr[1:0] has no effect. Indices 8, 12, 13, 14 and 15 read back the byte last written. Index 11 reads back the written byte ANDed with 0x15. After reset, index 14 reads 0x04 and every other index reads 0x00.
- R2: Writes to index 4 (status), 5 (interrupt), 6 (sequence step), 7 (FIFO level), 9 and 10 leave the readable value at that index unchanged. A write to index 4 sets the sel_target output to wdata[2:0].
- R3: A write to index 0 (counter low) or index 1 (counter high) clears status bit 4 (terminal count) but does not change the readable counter at indices 0 and 1. A write to index 3 (command) with bit 7 set sets dma_mode and copies both written counter bytes into the readable counter and dma_count. A command written with bit 7 clear clears dma_mode. Index 3 reads back the last command byte.
- R4: A write to index 2 pushes a byte into a 32-entry FIFO and is dropped when the FIFO is full. A read of index 2 while the FIFO holds data returns the oldest byte and removes it. A read of index 2 while the FIFO is empty returns the byte last removed. Index 7 reads the number of bytes held.
- R5: Reading index 5 returns the interrupt byte, leaves that byte unchanged, clears status bits 7, 6 and 5, and drops irq.
- R6: Command 0x01 (flush) empties the FIFO, sets interrupt to 0x08 and sequence step to 0, and does not change irq.
- R7: Command 0x03 (bus reset) sets interrupt to 0x80 and pulses bus_rst_go. It raises irq only when bit 6 of index 8 is 0.
- R8: Command 0x02 (chip reset) returns every register, the FIFO, dma_mode and irq to their reset values (R1).
- R9: Command 0x11 (command-complete) without the DMA bit loads the FIFO with exactly two bytes, sense_byte and then 0x00. It raises irq and leaves status, interrupt and sequence step unchanged.
- R10: Command 0x91 (command-complete with DMA) pulses resp_dma_go, sets status 0x93, interrupt 0x18 and sequence step 4, raises irq, and leaves the FIFO untouched.
- R11: Command 0x12 (message accepted) first does the same as command-complete in the selected mode, then sets interrupt to 0x20 and sequence step to 0.
- R12: Each of the commands 0x10, 0x1A, 0x42 and 0x43, with or without the DMA bit, gives a one-cycle pulse on xfer_go, atn_go, sel_go or sel_stop_go respectively. No other command pulses any of them.
- R13: upd_valid loads status, interrupt and sequence step from the update port and raises irq. In the same cycle a host command write overrides only the registers that command itself sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address; the index is bits 5:2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request |
| dma_mode | output | 1 | Last command carried the DMA bit |
| dma_count | output | 16 | Readable transfer counter for the DMA engine |
| sel_target | output | 3 | Target ID written at index 4 |
| xfer_go | output | 1 | Transfer-information start strobe |
| atn_go | output | 1 | Assert-attention strobe |
| sel_go | output | 1 | Select-with-attention start strobe |
| sel_stop_go | output | 1 | Select-with-attention-and-stop start strobe |
| bus_rst_go | output | 1 | Bus reset strobe |
| resp_dma_go | output | 1 | Status and message bytes go out by DMA |
| sense_byte | input | 8 | Status byte of the last command from the sequencer |
| upd_valid | input | 1 | Sequencer status update strobe |
| upd_status | input | 8 | New status byte |
| upd_intr | input | 8 | New interrupt byte |
| upd_seq | input | 8 | New sequence step |

## Verification
Every register effect of a write, every strobe and the irq line change at the clock edge that samples the access. The bench therefore checks them at the falling edge after that access, which is also the only falling edge at which a strobe is high. Read data is registered once and is due one edge after the select. A driver task queues the expected byte when it issues the read, and a monitor compares it 2 ns after that edge. Side effects of a read, such as a FIFO pop or the clearing of irq, show up in the next read or at the next falling edge.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;

    localparam int NUM_REGS = 16;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] IX_CNT_LO  = 4'd0;
    localparam logic [IDX_W-1:0] IX_CNT_HI  = 4'd1;
    localparam logic [IDX_W-1:0] IX_FIFO    = 4'd2;
    localparam logic [IDX_W-1:0] IX_CMD     = 4'd3;
    localparam logic [IDX_W-1:0] IX_STAT    = 4'd4;
    localparam logic [IDX_W-1:0] IX_INTR    = 4'd5;
    localparam logic [IDX_W-1:0] IX_SEQ     = 4'd6;
    localparam logic [IDX_W-1:0] IX_FLEVEL  = 4'd7;
    localparam logic [IDX_W-1:0] IX_CFG     = 4'd8;
    localparam logic [IDX_W-1:0] IX_MASKED  = 4'd11;
    localparam logic [IDX_W-1:0] IX_SPARE_A = 4'd12;
    localparam logic [IDX_W-1:0] IX_SPARE_B = 4'd13;
    localparam logic [IDX_W-1:0] IX_CHIP_ID = 4'd14;
    localparam logic [IDX_W-1:0] IX_SPARE_C = 4'd15;

    localparam logic [7:0] ST_TERM_CNT   = 8'h10;
    localparam logic [7:0] ST_KEEP_ON_RD = 8'h1F;
    localparam logic [7:0] ST_DMA_RESP   = 8'h93;
    localparam logic [7:0] IN_FUNC_DONE  = 8'h08;
    localparam logic [7:0] IN_DMA_RESP   = 8'h18;
    localparam logic [7:0] IN_DISCONNECT = 8'h20;
    localparam logic [7:0] IN_BUS_RESET  = 8'h80;
    localparam logic [7:0] SEQ_CMD_DONE  = 8'h04;
    localparam logic [7:0] CHIP_ID_VAL   = 8'h04;
    localparam logic [7:0] MASKED_KEEP   = 8'h15;
    localparam int         CFG_RST_QUIET = 6;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_FLUSH,
        OP_CHIP_RST,
        OP_BUS_RST,
        OP_XFER,
        OP_CMPL,
        OP_MSG_ACK,
        OP_ATN,
        OP_SEL_ATN,
        OP_SEL_STOP,
        OP_OTHER
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e op;
        logic    dma;
    } cmd_dec_t;

    function automatic cmd_op_e op_of(input logic [6:0] code);
        case (code)
            7'h00:   return OP_NOP;
            7'h01:   return OP_FLUSH;
            7'h02:   return OP_CHIP_RST;
            7'h03:   return OP_BUS_RST;
            7'h10:   return OP_XFER;
            7'h11:   return OP_CMPL;
            7'h12:   return OP_MSG_ACK;
            7'h1A:   return OP_ATN;
            7'h42:   return OP_SEL_ATN;
            7'h43:   return OP_SEL_STOP;
            default: return OP_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 push_byte,
    input  logic                         pop,
    input  logic                         load_pair,
    input  logic [W-1:0]                 pair_first,
    input  logic [W-1:0]                 pair_second,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (load_pair) begin
            mem[0] <= pair_first;
            mem[1] <= pair_second;
            wp     <= AW'(2);
            rp     <= '0;
            level  <= CW'(2);
        end else if (push && level < CW'(DEPTH)) begin
            mem[wp] <= push_byte;
            wp      <= wp + AW'(1);
            level   <= level + CW'(1);
        end else if (pop && level != '0) begin
            level <= level - CW'(1);
            if (level == CW'(1)) begin
                wp <= '0;
                rp <= '0;
            end else begin
                rp <= rp + AW'(1);
            end
        end
    end

    assign head = mem[rp];
endmodule

// File: rtl/scsi_regif_cmd_dec.sv
module scsi_regif_cmd_dec
    import scsi_regif_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_dec_t   dec
);
    always_comb begin
        dec.dma = cmd[7];
        dec.op  = op_of(cmd[6:0]);
    end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
    import scsi_regif_pkg::*;
#(
    parameter int FIFO_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        we,
    input  logic [5:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq,
    output logic        dma_mode,
    output logic [15:0] dma_count,
    output logic [2:0]  sel_target,
    output logic        xfer_go,
    output logic        atn_go,
    output logic        sel_go,
    output logic        sel_stop_go,
    output logic        bus_rst_go,
    output logic        resp_dma_go,
    input  logic [7:0]  sense_byte,
    input  logic        upd_valid,
    input  logic [7:0]  upd_status,
    input  logic [7:0]  upd_intr,
    input  logic [7:0]  upd_seq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [7:0]       rreg [NUM_REGS];
    logic [7:0]       wcnt_lo, wcnt_hi, pop_q;
    logic [IDX_W-1:0] idx;
    logic             addr_lo_unused;
    logic             host_rd, host_wr, cmd_wr, rd_intr, soft_rst, flush, load_resp;
    cmd_dec_t         dec;
    logic [7:0]       fifo_head, fflag_val;
    logic [CNT_W-1:0] fifo_level;
    logic [7:0]       st_base, in_base, sq_base;
    logic             irq_base, busrst_masked;

    assign idx            = addr[5:2];
    assign addr_lo_unused = ^addr[1:0];
    assign host_rd        = cs && !we;
    assign host_wr        = cs && we;
    assign cmd_wr         = host_wr && idx == IX_CMD;
    assign rd_intr        = host_rd && idx == IX_INTR;

    scsi_regif_cmd_dec u_dec (.cmd(wdata), .dec(dec));

    assign soft_rst  = cmd_wr && dec.op == OP_CHIP_RST;
    assign flush     = cmd_wr && dec.op == OP_FLUSH;
    assign load_resp = cmd_wr && !dec.dma && (dec.op == OP_CMPL || dec.op == OP_MSG_ACK);

    scsi_regif_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .clr         (soft_rst || flush),
        .push        (host_wr && idx == IX_FIFO),
        .push_byte   (wdata),
        .pop         (host_rd && idx == IX_FIFO),
        .load_pair   (load_resp),
        .pair_first  (sense_byte),
        .pair_second (8'h00),
        .head        (fifo_head),
        .level       (fifo_level)
    );

    assign fflag_val     = 8'(fifo_level);
    assign busrst_masked = rreg[IX_CFG][CFG_RST_QUIET];

    // Sequencer update first; the read-clear of the interrupt register acts on held state.
    always_comb begin
        st_base  = rd_intr ? (rreg[IX_STAT] & ST_KEEP_ON_RD) : rreg[IX_STAT];
        in_base  = rreg[IX_INTR];
        sq_base  = rreg[IX_SEQ];
        irq_base = rd_intr ? 1'b0 : irq;
        if (upd_valid) begin
            st_base  = upd_status;
            in_base  = upd_intr;
            sq_base  = upd_seq;
            irq_base = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            for (int i = 0; i < NUM_REGS; i++) rreg[i] <= '0;
            rreg[IX_CHIP_ID] <= CHIP_ID_VAL;
            wcnt_lo     <= '0;
            wcnt_hi     <= '0;
            pop_q       <= '0;
            sel_target  <= '0;
            dma_mode    <= 1'b0;
            irq         <= 1'b0;
            xfer_go     <= 1'b0;
            atn_go      <= 1'b0;
            sel_go      <= 1'b0;
            sel_stop_go <= 1'b0;
            bus_rst_go  <= 1'b0;
            resp_dma_go <= 1'b0;
        end else begin
            xfer_go     <= 1'b0;
            atn_go      <= 1'b0;
            sel_go      <= 1'b0;
            sel_stop_go <= 1'b0;
            bus_rst_go  <= 1'b0;
            resp_dma_go <= 1'b0;
            rreg[IX_STAT] <= st_base;
            rreg[IX_INTR] <= in_base;
            rreg[IX_SEQ]  <= sq_base;
            irq           <= irq_base;
            if (host_rd && idx == IX_FIFO && fifo_level != '0) pop_q <= fifo_head;
            if (host_wr) begin
                case (idx)
                    IX_CNT_LO: begin
                        wcnt_lo       <= wdata;
                        rreg[IX_STAT] <= st_base & ~ST_TERM_CNT;
                    end
                    IX_CNT_HI: begin
                        wcnt_hi       <= wdata;
                        rreg[IX_STAT] <= st_base & ~ST_TERM_CNT;
                    end
                    IX_CMD: begin
                        rreg[IX_CMD] <= wdata;
                        dma_mode     <= dec.dma;
                        if (dec.dma) begin
                            rreg[IX_CNT_LO] <= wcnt_lo;
                            rreg[IX_CNT_HI] <= wcnt_hi;
                        end
                        case (dec.op)
                            OP_FLUSH: begin
                                rreg[IX_INTR] <= IN_FUNC_DONE;
                                rreg[IX_SEQ]  <= '0;
                            end
                            OP_BUS_RST: begin
                                rreg[IX_INTR] <= IN_BUS_RESET;
                                bus_rst_go    <= 1'b1;
                                if (!busrst_masked) irq <= 1'b1;
                            end
                            OP_XFER:     xfer_go     <= 1'b1;
                            OP_ATN:      atn_go      <= 1'b1;
                            OP_SEL_ATN:  sel_go      <= 1'b1;
                            OP_SEL_STOP: sel_stop_go <= 1'b1;
                            OP_CMPL, OP_MSG_ACK: begin
                                irq <= 1'b1;
                                if (dec.dma) begin
                                    resp_dma_go   <= 1'b1;
                                    rreg[IX_STAT] <= ST_DMA_RESP;
                                    rreg[IX_INTR] <= IN_DMA_RESP;
                                    rreg[IX_SEQ]  <= SEQ_CMD_DONE;
                                end
                                if (dec.op == OP_MSG_ACK) begin
                                    rreg[IX_INTR] <= IN_DISCONNECT;
                                    rreg[IX_SEQ]  <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                    IX_STAT:   sel_target <= wdata[2:0];
                    IX_MASKED: rreg[IX_MASKED] <= wdata & MASKED_KEEP;
                    IX_CFG, IX_SPARE_A, IX_SPARE_B, IX_CHIP_ID, IX_SPARE_C:
                        rreg[idx] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (host_rd) begin
            case (idx)
                IX_FIFO:   rdata <= (fifo_level != '0) ? fifo_head : pop_q;
                IX_FLEVEL: rdata <= fflag_val;
                default:   rdata <= rreg[idx];
            endcase
        end
    end

    assign dma_count = {rreg[IX_CNT_HI], rreg[IX_CNT_LO]};
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk #(
    parameter int DEPTH = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       cs,
    input logic       we,
    input logic [5:0] addr,
    input logic [7:0] wdata,
    input logic       upd_valid,
    input logic       irq,
    input logic       dma_mode,
    input logic       busrst_masked,
    input logic [7:0] fflag_val,
    input logic       xfer_go,
    input logic       atn_go,
    input logic       sel_go,
    input logic       sel_stop_go,
    input logic       bus_rst_go,
    input logic       resp_dma_go
);
    // R5
    intr_read_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && addr[5:2] == 4'd5 && !upd_valid) |=> !irq);

    // R7
    bus_rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[5:2] == 4'd3 && wdata[6:0] == 7'h03 && busrst_masked
         && !irq && !upd_valid) |=> !irq);

    // R7
    bus_rst_loud_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[5:2] == 4'd3 && wdata[6:0] == 7'h03 && !busrst_masked) |=> irq);

    // R3
    dma_mode_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[5:2] == 4'd3 && wdata[7] && wdata[6:0] != 7'h02) |=> dma_mode);

    // R3
    dma_mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[5:2] == 4'd3 && !wdata[7]) |=> !dma_mode);

    // R8
    chip_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[5:2] == 4'd3 && wdata[6:0] == 7'h02) |=> (!irq && !dma_mode));

    // R12
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xfer_go, atn_go, sel_go, sel_stop_go, bus_rst_go, resp_dma_go}));

    // R12
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_go || atn_go || sel_go || sel_stop_go) |-> $past(cs && we && addr[5:2] == 4'd3));

    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fflag_val <= 8'(DEPTH));
endmodule

bind scsi_regif scsi_regif_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cs            (cs),
    .we            (we),
    .addr          (addr),
    .wdata         (wdata),
    .upd_valid     (upd_valid),
    .irq           (irq),
    .dma_mode      (dma_mode),
    .busrst_masked (busrst_masked),
    .fflag_val     (fflag_val),
    .xfer_go       (xfer_go),
    .atn_go        (atn_go),
    .sel_go        (sel_go),
    .sel_stop_go   (sel_stop_go),
    .bus_rst_go    (bus_rst_go),
    .resp_dma_go   (resp_dma_go)
);

// File: tb/scsi_regif_tb.sv
`timescale 1ns/1ps
module scsi_regif_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq, dma_mode;
    logic [15:0] dma_count;
    logic [2:0]  sel_target;
    logic        xfer_go, atn_go, sel_go, sel_stop_go, bus_rst_go, resp_dma_go;
    logic [7:0]  sense_byte = '0;
    logic        upd_valid = 1'b0;
    logic [7:0]  upd_status = '0, upd_intr = '0, upd_seq = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen;

    always #4 clk = ~clk;

    scsi_regif u_dut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .dma_mode(dma_mode), .dma_count(dma_count),
        .sel_target(sel_target), .xfer_go(xfer_go), .atn_go(atn_go),
        .sel_go(sel_go), .sel_stop_go(sel_stop_go), .bus_rst_go(bus_rst_go),
        .resp_dma_go(resp_dma_go), .sense_byte(sense_byte),
        .upd_valid(upd_valid), .upd_status(upd_status), .upd_intr(upd_intr),
        .upd_seq(upd_seq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected byte for every read the driver issued
    always begin
        @(posedge clk);
        rd_seen = cs && !we && !rst;
        #2;
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard: actual=%0h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr_a(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] d);
        wr_a({ix, 2'b00}, d);
    endtask

    task automatic rd_a(input logic [5:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix, input logic [7:0] exp, input string tag);
        rd_a({ix, 2'b00}, exp, tag);
    endtask

    task automatic upd(input logic [7:0] s, input logic [7:0] i, input logic [7:0] q);
        @(negedge clk);
        upd_valid = 1'b1; upd_status = s; upd_intr = i; upd_seq = q;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    function automatic logic [3:0] strobes();
        return {xfer_go, atn_go, sel_go, sel_stop_go};
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 / R8 reset state
        check("R1 irq after reset", irq, 0);
        check("R1 dma_mode after reset", dma_mode, 0);
        check("R1 dma_count after reset", dma_count, 0);
        rd(14, 8'h04, "R1 chip id");
        rd(4, 8'h00, "R1 status reset");
        rd(7, 8'h00, "R1 fifo level reset");

        // R1 decode and readback
        wr_a(6'd51, 8'hA5);
        rd_a(6'd50, 8'hA5, "R1 index 12 via low bits");
        wr(11, 8'hFF);
        rd(11, 8'h15, "R1 index 11 mask");
        wr(8, 8'h40);
        rd(8, 8'h40, "R1 config readback");
        wr(13, 8'h3C);
        rd(13, 8'h3C, "R1 index 13 readback");

        // R2 writes that do not reach readable values
        wr(5, 8'hFF); wr(6, 8'hFF); wr(9, 8'h77); wr(10, 8'h55); wr(4, 8'h05); wr(7, 8'h09);
        rd(5, 8'h00, "R2 intr");
        rd(6, 8'h00, "R2 seq");
        rd(9, 8'h00, "R2 index 9");
        rd(10, 8'h00, "R2 index 10");
        rd(4, 8'h00, "R2 status");
        rd(7, 8'h00, "R2 fifo level");
        check("R2 sel_target", sel_target, 5);

        // R13 update port
        upd(8'hF7, 8'h10, 8'h02);
        check("R13 irq raised", irq, 1);
        rd(4, 8'hF7, "R13 status loaded");
        rd(6, 8'h02, "R13 seq loaded");

        // R5 interrupt read
        rd(5, 8'h10, "R5 intr value");
        check("R5 irq cleared", irq, 0);
        rd(4, 8'h17, "R5 status bits 7:5 cleared");
        rd(5, 8'h10, "R5 intr kept");

        // R3 counter and DMA qualifier
        wr(0, 8'h34);
        rd(4, 8'h07, "R3 terminal count cleared");
        wr(1, 8'h12);
        rd(0, 8'h00, "R3 counter low not yet copied");
        rd(1, 8'h00, "R3 counter high not yet copied");
        wr(3, 8'h80);
        check("R3 dma_mode set", dma_mode, 1);
        check("R3 dma_count", dma_count, 16'h1234);
        rd(0, 8'h34, "R3 counter low copied");
        rd(1, 8'h12, "R3 counter high copied");
        rd(3, 8'h80, "R3 command readback");
        wr(3, 8'h00);
        check("R3 dma_mode clear", dma_mode, 0);
        rd(0, 8'h34, "R3 counter kept");

        // R4 FIFO
        wr(2, 8'h11); wr(2, 8'h22); wr(2, 8'h33);
        rd(7, 8'h03, "R4 level 3");
        rd(2, 8'h11, "R4 pop 1");
        rd(2, 8'h22, "R4 pop 2");
        rd(7, 8'h01, "R4 level 1");
        rd(2, 8'h33, "R4 pop 3");
        rd(7, 8'h00, "R4 level 0");
        rd(2, 8'h33, "R4 empty read repeats");
        for (int i = 0; i < 33; i++) wr(2, 8'h40 + 8'(i));
        rd(7, 8'h20, "R4 full level");
        rd(2, 8'h40, "R4 pop after fill");
        rd(2, 8'h41, "R4 second pop");
        rd(7, 8'h1E, "R4 level after pops");

        // R6 flush
        wr(3, 8'h01);
        check("R6 irq untouched", irq, 0);
        rd(7, 8'h00, "R6 fifo emptied");
        rd(5, 8'h08, "R6 intr");
        rd(6, 8'h00, "R6 seq");
        rd(2, 8'h41, "R6 empty read");

        // R9 command complete, programmed I/O
        sense_byte = 8'h02;
        wr(3, 8'h11);
        check("R9 irq", irq, 1);
        rd(7, 8'h02, "R9 level 2");
        rd(2, 8'h02, "R9 status byte");
        rd(2, 8'h00, "R9 message byte");
        rd(4, 8'h07, "R9 status unchanged");
        rd(5, 8'h08, "R9 intr unchanged");

        // R10 command complete, DMA
        wr(3, 8'h91);
        check("R10 resp_dma_go", resp_dma_go, 1);
        check("R10 irq", irq, 1);
        rd(4, 8'h93, "R10 status");
        rd(6, 8'h04, "R10 seq");
        rd(5, 8'h18, "R10 intr");
        rd(4, 8'h13, "R10 status after intr read");
        rd(7, 8'h00, "R10 fifo untouched");

        // R11 message accepted
        sense_byte = 8'h81;
        wr(3, 8'h12);
        check("R11 irq", irq, 1);
        rd(5, 8'h20, "R11 intr disconnect");
        rd(6, 8'h00, "R11 seq");
        rd(7, 8'h02, "R11 level");
        rd(2, 8'h81, "R11 status byte");
        rd(2, 8'h00, "R11 message byte");

        // R12 sequencer strobes
        wr(3, 8'h10); check("R12 xfer_go", strobes(), 4'b1000);
        wr(3, 8'h1A); check("R12 atn_go", strobes(), 4'b0100);
        wr(3, 8'h42); check("R12 sel_go", strobes(), 4'b0010);
        wr(3, 8'h43); check("R12 sel_stop_go", strobes(), 4'b0001);
        wr(3, 8'h90); check("R12 xfer_go with DMA", strobes(), 4'b1000);
        wr(3, 8'h00); check("R12 NOP no strobe", {strobes(), bus_rst_go, resp_dma_go}, 6'b0);

        // R7 bus reset with and without the mask bit
        wr(3, 8'h03);
        check("R7 bus_rst_go", bus_rst_go, 1);
        check("R7 irq masked", irq, 0);
        rd(5, 8'h80, "R7 intr");
        wr(8, 8'h00);
        wr(3, 8'h03);
        check("R7 irq unmasked", irq, 1);
        rd(5, 8'h80, "R7 intr again");

        // R13 precedence: update and flush in the same cycle
        @(negedge clk);
        upd_valid = 1'b1; upd_status = 8'h05; upd_intr = 8'h10; upd_seq = 8'h03;
        cs = 1'b1; we = 1'b1; addr = {4'd3, 2'b00}; wdata = 8'h01;
        @(negedge clk);
        upd_valid = 1'b0; cs = 1'b0; we = 1'b0;
        check("R13 irq with command", irq, 1);
        rd(4, 8'h05, "R13 status from port");
        rd(6, 8'h00, "R13 seq from command");
        rd(5, 8'h08, "R13 intr from command");

        // R8 chip reset
        wr(0, 8'h77);
        wr(3, 8'h80);
        wr(2, 8'h5A);
        upd(8'h01, 8'h01, 8'h01);
        wr(3, 8'h02);
        check("R8 irq", irq, 0);
        check("R8 dma_mode", dma_mode, 0);
        check("R8 dma_count", dma_count, 0);
        rd(7, 8'h00, "R8 fifo");
        rd(14, 8'h04, "R8 chip id");
        rd(12, 8'h00, "R8 index 12");
        rd(13, 8'h00, "R8 index 13");
        rd(11, 8'h00, "R8 index 11");
        rd(4, 8'h00, "R8 status");
        rd(3, 8'h00, "R8 command");

        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule